// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Receiver

This block listens to the two-wire clock/data bus of a PS/2 keyboard and turns the serial traffic into classified key events. Both lines are brought into the system clock domain through a two-flop synchroniser and a glitch filter. Each bit is captured when the filtered keyboard clock falls. Every 11-bit frame is then checked for its start bit, stop bit and odd parity.

Accepted bytes go to a small prefix tracker. It remembers whether a release marker (0xF0) or an extended marker (0xE0) has been seen. When a byte arrives that is neither marker, the tracker emits a single event with the scan code, a release flag and an extended flag. A marker byte on its own produces no output. A bad frame produces a one-cycle error pulse and discards any marker still pending. A frame that stalls part-way is abandoned after a programmable number of idle system cycles. The host side only receives; it never drives the bus.

Top module: `ps2_key_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `evt_valid_o` and `frame_err_o` are low.
- R2: A frame is a 0 start bit, 8 data bits with the least significant bit first, a parity bit that makes the 9 data-plus-parity bits contain an odd number of ones, and a 1 stop bit. A well-formed frame whose byte is neither 0xF0 nor 0xE0 and that follows no marker yields a press event: code = the byte, `evt_break_o`=0, `evt_ext_o`=0.
- R3: The byte 0xF0 followed by a code byte yields one event with `evt_break_o`=1 and `evt_ext_o`=0.
- R4: 0xE0 followed by a code byte yields an event with `evt_ext_o`=1 and `evt_break_o`=0. The sequence E0 F0 code yields an event with both flags set.
- R5: A marker byte (0xF0 or 0xE0) never raises `evt_valid_o`. `evt_valid_o` is high for exactly one cycle per completed sequence.
- R6: The same press code received repeatedly yields one fresh press event each time.
- R7: A frame with a wrong start bit, a wrong stop bit or wrong parity produces no event. It raises `frame_err_o` for one cycle and clears any pending marker, so the next code byte is reported as a plain press.
- R8: If no falling keyboard-clock edge arrives for TIMEOUT_CYC system cycles while a frame is partly received, the receiver discards the partial frame. The next frame is then decoded from its start bit.
- R9: A low pulse on the keyboard clock shorter than FILT_LEN system cycles is ignored and does not shift a bit in.
- R10: The event or error pulse for a frame is high in the cycle that follows the (FILT_LEN+3)-th rising system-clock edge after the edge that first samples the frame's final falling keyboard-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the keyboard clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_i | input | 1 | Keyboard clock line (idles high) |
| ps2_dat_i | input | 1 | Keyboard data line (idles high) |
| evt_valid_o | output | 1 | One-cycle strobe marking a completed key event |
| evt_code_o | output | 8 | Scan code of the event |
| evt_break_o | output | 1 | 1 when the event is a key release |
| evt_ext_o | output | 1 | 1 when the event belongs to an extended key |
| frame_err_o | output | 1 | One-cycle pulse for a rejected frame |

## Verification
Every result falls due at a fixed distance from the stimulus. The bench drives each keyboard-clock fall at a falling system-clock edge. The matching event or error pulse is expected FILT_LEN+4 system cycles later, counted as the two synchroniser flops, the filter's FILT_LEN qualifying cycles, the frame register and the event register. The bench's behavioural model files each expected result in a queue under that due cycle. On every falling system-clock edge the model compares the strobes and fields against the head of the queue, so an early, late, missing or extra pulse is caught in the exact cycle it occurs. Marker-only bytes, glitches and abandoned partial frames enqueue nothing, so any strobe they cause counts as a mismatch.

// File: rtl/ps2_key_rx_pkg.sv
package ps2_key_rx_pkg;

    localparam int          FRAME_BITS = 11;
    localparam logic [7:0]  CODE_BREAK = 8'hF0;
    localparam logic [7:0]  CODE_EXTND = 8'hE0;

    typedef struct packed {
        logic [7:0] code;
        logic       brk;
        logic       ext;
    } key_evt_t;

    typedef struct packed {
        logic brk;
        logic ext;
    } pend_t;

    // Frame bits: [0] start, [8:1] data LSB first, [9] parity, [10] stop
    function automatic logic frame_ok(input logic [FRAME_BITS-1:0] f);
        return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) && (^f[9:1] == 1'b1);
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
    parameter int FILT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                cnt_q  <= '0;
                filt_q <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_key_rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kclk_i,
    input  logic       kdat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       err_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int BW = $clog2(FRAME_BITS + 1);

    logic                  kclk_d;
    logic                  fall;
    logic [BW-1:0]         bitcnt_q;
    logic [TW-1:0]         idle_q;
    logic [FRAME_BITS-2:0] sh_q;
    logic [FRAME_BITS-1:0] full;
    logic                  last_bit;

    assign fall     = kclk_d & ~kclk_i;
    assign full     = {kdat_i, sh_q};
    assign last_bit = (bitcnt_q == BW'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            kclk_d     <= 1'b1;
            bitcnt_q   <= '0;
            idle_q     <= '0;
            sh_q       <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            err_o      <= 1'b0;
        end else begin
            kclk_d     <= kclk_i;
            byte_vld_o <= 1'b0;
            err_o      <= 1'b0;
            if (fall) begin
                idle_q <= '0;
                sh_q   <= full[FRAME_BITS-1:1];
                if (last_bit) begin
                    bitcnt_q <= '0;
                    if (frame_ok(full)) begin
                        byte_vld_o <= 1'b1;
                        byte_o     <= full[8:1];
                    end else begin
                        err_o <= 1'b1;
                    end
                end else begin
                    bitcnt_q <= bitcnt_q + 1'b1;
                end
            end else if (bitcnt_q != '0) begin
                if (idle_q == TW'(TIMEOUT_CYC - 1)) begin
                    idle_q   <= '0;
                    bitcnt_q <= '0;
                end else begin
                    idle_q <= idle_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_key_decode.sv
module ps2_key_decode
    import ps2_key_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       err_i,
    output logic       evt_vld_o,
    output key_evt_t   evt_o,
    output logic       err_o
);
    pend_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            evt_vld_o <= 1'b0;
            evt_o     <= '0;
            err_o     <= 1'b0;
        end else begin
            evt_vld_o <= 1'b0;
            err_o     <= err_i;
            if (err_i) begin
                pend_q <= '0;
            end else if (byte_vld_i) begin
                if (byte_i == CODE_BREAK) begin
                    pend_q.brk <= 1'b1;
                end else if (byte_i == CODE_EXTND) begin
                    pend_q.ext <= 1'b1;
                end else begin
                    evt_vld_o  <= 1'b1;
                    evt_o.code <= byte_i;
                    evt_o.brk  <= pend_q.brk;
                    evt_o.ext  <= pend_q.ext;
                    pend_q     <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/ps2_key_rx.sv
module ps2_key_rx
    import ps2_key_rx_pkg::*;
#(
    parameter int FILT_LEN    = 16,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       evt_valid_o,
    output logic [7:0] evt_code_o,
    output logic       evt_break_o,
    output logic       evt_ext_o,
    output logic       frame_err_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] clean;
    logic              byte_vld;
    logic [7:0]        byte_val;
    logic              byte_err;
    key_evt_t          evt;

    assign raw = {ps2_dat_i, ps2_clk_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw[g]),
            .line_o (clean[g])
        );
    end

    ps2_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .kclk_i     (clean[0]),
        .kdat_i     (clean[1]),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val),
        .err_o      (byte_err)
    );

    ps2_key_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_val),
        .err_i      (byte_err),
        .evt_vld_o  (evt_valid_o),
        .evt_o      (evt),
        .err_o      (frame_err_o)
    );

    assign evt_code_o  = evt.code;
    assign evt_break_o = evt.brk;
    assign evt_ext_o   = evt.ext;
endmodule

// File: rtl/ps2_key_rx_chk.sv
module ps2_key_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       evt_valid,
    input logic [7:0] evt_code,
    input logic       frame_err,
    input logic       byte_vld
);
    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> !evt_valid); // R5

    AST_NO_MARKER_EVT: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> (evt_code != 8'hF0 && evt_code != 8'hE0)); // R5

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err); // R7

    AST_ERR_NOT_EVT: assert property (@(posedge clk) disable iff (rst)
        !(evt_valid && frame_err)); // R7

    AST_EVT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_valid) |-> $past(byte_vld)); // R10
endmodule

bind ps2_key_rx ps2_key_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid_o),
    .evt_code  (evt_code_o),
    .frame_err (frame_err_o),
    .byte_vld  (byte_vld)
);

// File: tb/ps2_key_rx_tb.sv
module ps2_key_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FLT        = 4;
    localparam int TMO        = 200;
    localparam int HALF       = 20;
    localparam int LAT        = FLT + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ps2c = 1'b1;
    logic       ps2d = 1'b1;
    logic       evt_valid;
    logic [7:0] evt_code;
    logic       evt_break;
    logic       evt_ext;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    string phase_req = "R1";

    typedef struct {
        int         due;
        logic [7:0] code;
        logic       brk;
        logic       ext;
        logic       err;
        string      req;
    } exp_t;
    exp_t q[$];

    logic pend_brk = 1'b0;
    logic pend_ext = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ps2_key_rx #(.FILT_LEN(FLT), .TIMEOUT_CYC(TMO)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .ps2_clk_i   (ps2c),
        .ps2_dat_i   (ps2d),
        .evt_valid_o (evt_valid),
        .evt_code_o  (evt_code),
        .evt_break_o (evt_break),
        .evt_ext_o   (evt_ext),
        .frame_err_o (frame_err)
    );

    // Per-cycle comparison against the queued expectations (R10 timing)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (q.size() > 0 && q[0].due == cyc) begin
                if (q[0].err) begin
                    if (frame_err !== 1'b1 || evt_valid !== 1'b0) begin
                        errors++;
                        $display("FAIL %s/R10 err pulse: valid=%b err=%b expected valid=0 err=1 at cycle %0d",
                                 q[0].req, evt_valid, frame_err, cyc);
                    end
                end else if (evt_valid !== 1'b1 || frame_err !== 1'b0 || evt_code !== q[0].code ||
                             evt_break !== q[0].brk || evt_ext !== q[0].ext) begin
                    errors++;
                    $display("FAIL %s/R10 event: valid=%b err=%b code=%02h brk=%b ext=%b expected 1 0 %02h %b %b at cycle %0d",
                             q[0].req, evt_valid, frame_err, evt_code, evt_break, evt_ext,
                             q[0].code, q[0].brk, q[0].ext, cyc);
                end
                void'(q.pop_front());
            end else if (evt_valid !== 1'b0 || frame_err !== 1'b0) begin
                errors++;
                $display("FAIL %s/R5 unexpected strobe: valid=%b err=%b expected 0 0 at cycle %0d",
                         phase_req, evt_valid, frame_err, cyc);
            end
        end
    end

    // mode: 0 good, 1 bad parity, 2 bad start, 3 bad stop; nbits < 11 sends a partial frame
    task automatic send(input logic [7:0] b, input int mode, input string req, input int nbits = 11);
        logic [10:0] f;
        exp_t e;
        f = {1'b1, ~(^b), b, 1'b0};
        if (mode == 1) f[9]  = ~f[9];
        if (mode == 2) f[0]  = 1'b1;
        if (mode == 3) f[10] = 1'b0;
        phase_req = req;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            ps2d = f[i];
            repeat (HALF) @(negedge clk);
            ps2c = 1'b0;
            if (i == 10) begin
                e.due = cyc + LAT; e.code = b; e.brk = pend_brk; e.ext = pend_ext; e.req = req;
                if (mode != 0) begin
                    e.err = 1'b1; pend_brk = 1'b0; pend_ext = 1'b0; q.push_back(e);
                end else if (b == 8'hF0) begin
                    pend_brk = 1'b1;
                end else if (b == 8'hE0) begin
                    pend_ext = 1'b1;
                end else begin
                    e.err = 1'b0; pend_brk = 1'b0; pend_ext = 1'b0; q.push_back(e);
                end
            end
            repeat (HALF) @(negedge clk);
            ps2c = 1'b1;
        end
        @(negedge clk);
        ps2d = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        checks++;
        if (evt_valid !== 1'b0 || frame_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: valid=%b err=%b expected 0 0", evt_valid, frame_err);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (evt_valid !== 1'b0 || frame_err !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: valid=%b err=%b expected 0 0", evt_valid, frame_err);
        end

        send(8'h1C, 0, "R2");
        send(8'h5A, 0, "R2");
        send(8'h81, 0, "R2");
        send(8'hF0, 0, "R3");   // marker: no strobe (R5)
        send(8'h1C, 0, "R3");
        send(8'hE0, 0, "R4");
        send(8'h75, 0, "R4");
        send(8'hE0, 0, "R4");
        send(8'hF0, 0, "R5");
        send(8'h75, 0, "R4");
        for (int k = 0; k < 3; k++) send(8'h29, 0, "R6");
        send(8'hE0, 0, "R7");
        send(8'h1C, 1, "R7");
        send(8'h1C, 0, "R7");
        send(8'hF0, 0, "R7");
        send(8'h33, 2, "R7");
        send(8'h33, 0, "R7");
        send(8'h44, 3, "R7");
        send(8'h44, 0, "R7");

        // R8: abandoned partial frame, then a full one
        send(8'h12, 0, "R8", 5);
        repeat (TMO + 50) @(negedge clk);
        send(8'h4B, 0, "R8");

        // R9: short clock glitches must not shift bits in
        for (int k = 0; k < 4; k++) begin
            phase_req = "R9";
            @(negedge clk); ps2c = 1'b0;
            repeat (FLT - 2) @(negedge clk);
            ps2c = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        send(8'h2D, 0, "R9");

        repeat (LAT + 20) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R10 missing results: %0d pending expected 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired: running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule